// File: doc/BRIEF.md
# System Reset Request Generator

This block merges every reason a small microcontroller has to reset itself into one held system reset. There are three sources. The first is an active-high external reset pin, which is synchronised and then only looked at on a 2 kHz sampling strobe. The second is a key chord: two, three or four of the low port lines held down together, seen on two back-to-back 1 Hz samples. The third is a flag from an oscillator-stop detector, which counts only when an option enables it.

Any request sets a latch whose output is the system reset. A second output, which clears the time-base counter, follows the sampled requests directly. The latch drops only when a release pulse arrives while no source is still active. A constant all-zero restart address is also provided. The sampling strobes are single-cycle enables in the system clock domain. The reset input `por` is synchronous and active high, and it forces the system reset on.

Top module: `sysrst_gen`

## Requirements
- R1: While `por` is high, and after it falls, `sys_rst` reads 1. All sampled request state is cleared, so `tbc_clr` reads 0 with idle inputs.
- R2: `ext_rst_pin` passes through a two-flop synchroniser and is then captured only in cycles where `stb_2k` is high. A pin that is high while no strobe occurs causes no reset.
- R3: The chord uses the `chord_sel` encoding 2'b00 for lines 0–1, 2'b01 for lines 0–2, and 2'b10 or 2'b11 for lines 0–3. A chord is present when every selected line of `key_in` is 1. Unselected lines are ignored.
- R4: A chord is accepted only when it is present on two consecutive `stb_1hz` samples. A sample without the chord between two samples with it prevents acceptance.
- R5: `osc_stopped` requests a reset only when `osc_chk_en` is 1.
- R6: Any active sampled request sets `sys_rst` on the next clock edge. `sys_rst` stays set after the request goes away.
- R7: `sys_rst` clears on a `release_pulse` only when no sampled request is active. An active request has priority over the release.
- R8: `tbc_clr` is 1 exactly while at least one sampled request is active.
- R9: `rst_vector` is constantly 16'h0000.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por | input | 1 | Synchronous power-on reset, active high |
| stb_2k | input | 1 | Single-cycle 2 kHz pin sampling enable |
| stb_1hz | input | 1 | Single-cycle 1 Hz key sampling enable |
| ext_rst_pin | input | 1 | External reset pin, active high, asynchronous |
| key_in | input | 4 | Port key lines 0 to 3, 1 = pressed |
| osc_stopped | input | 1 | Low-frequency oscillator stopped flag |
| chord_sel | input | 2 | Static chord width option |
| osc_chk_en | input | 1 | Static option enabling the oscillator-stop source |
| release_pulse | input | 1 | Request to drop the system reset |
| sys_rst | output | 1 | Latched system reset |
| tbc_clr | output | 1 | Time-base counter clear |
| rst_vector | output | 16 | Restart address, always zero |

## Verification
The bench goes after the chord boundaries. A chord that is one line short of its option must not be accepted, and set lines outside the option must not matter. A design with the wrong mask would accept three keys as four, or reject a two-key chord because line 3 is idle. It checks that one 1 Hz sample is not enough, and that a gap between samples restarts the count. A single-stage check would reset on a brief press. It also holds the pin high with no strobe present and releases while a source is still active. Here a design that ignores the strobe, or lets release win, would drop or raise the reset at the wrong moment.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    localparam int NKEY      = 4;
    localparam int VEC_W     = 16;
    localparam int SYNC_W    = 2;

    typedef enum logic [1:0] {
        CHORD_TWO   = 2'b00,
        CHORD_THREE = 2'b01,
        CHORD_FOUR  = 2'b10,
        CHORD_FOUR2 = 2'b11
    } chord_sel_e;

    typedef struct packed {
        logic pin;
        logic chord;
        logic osc;
    } req_t;

    function automatic logic [NKEY-1:0] chord_mask(input chord_sel_e sel);
        logic [NKEY-1:0] m;
        case (sel)
            CHORD_TWO:   m = 4'b0011;
            CHORD_THREE: m = 4'b0111;
            default:     m = 4'b1111;
        endcase
        return m;
    endfunction

    function automatic logic any_req(input req_t r);
        return r.pin | r.chord | r.osc;
    endfunction

endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sysrst_pin_smp.sv
module sysrst_pin_smp (
    input  logic clk,
    input  logic rst,
    input  logic stb,
    input  logic pin_sync,
    output logic pin_req
);
    always_ff @(posedge clk) begin
        if (rst)      pin_req <= 1'b0;
        else if (stb) pin_req <= pin_sync;
    end

    // R2: the sampled pin may only change on a strobe cycle
    p_pin_on_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        (pin_req != $past(pin_req)) |-> $past(stb));
endmodule

// File: rtl/sysrst_chord.sv
module sysrst_chord
    import sysrst_pkg::*;
#(
    parameter int N = NKEY
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb,
    input  chord_sel_e   sel,
    input  logic [N-1:0] keys,
    output logic         chord_req
);
    logic [N-1:0] mask;
    logic [N-1:0] line_ok;
    logic         chord_now;
    logic         smp_cur, smp_prev;

    assign mask = chord_mask(sel);

    for (genvar i = 0; i < N; i++) begin : g_line
        assign line_ok[i] = keys[i] | ~mask[i];
    end

    assign chord_now = &line_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp_cur  <= 1'b0;
            smp_prev <= 1'b0;
        end else if (stb) begin
            smp_cur  <= chord_now;
            smp_prev <= smp_cur;
        end
    end

    assign chord_req = smp_cur & smp_prev;

    // R4: acceptance only appears right after a 1 Hz sample
    p_chord_on_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(chord_req) |-> $past(stb));
    // R4: accepted chord needs the previous sample to have held it
    p_chord_two_samples_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(chord_req) |-> $past(smp_cur));
endmodule

// File: rtl/sysrst_latch.sv
module sysrst_latch
    import sysrst_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  req_t req,
    input  logic release_pulse,
    output logic sys_rst
);
    logic active;

    assign active = any_req(req);

    always_ff @(posedge clk) begin
        if (rst)                 sys_rst <= 1'b1;
        else if (active)         sys_rst <= 1'b1;
        else if (release_pulse)  sys_rst <= 1'b0;
    end

    // R6: any active request sets the latch on the next edge
    p_set_on_req_r6: assert property (@(posedge clk) disable iff (rst)
        active |=> sys_rst);
    // R7: release with no source clears the latch
    p_release_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (release_pulse && !active) |=> !sys_rst);
    // R6: latch holds without release
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (sys_rst && !release_pulse) |=> sys_rst);
endmodule

// File: rtl/sysrst_gen.sv
module sysrst_gen
    import sysrst_pkg::*;
(
    input  logic             clk,
    input  logic             por,
    input  logic             stb_2k,
    input  logic             stb_1hz,
    input  logic             ext_rst_pin,
    input  logic [NKEY-1:0]  key_in,
    input  logic             osc_stopped,
    input  logic [1:0]       chord_sel,
    input  logic             osc_chk_en,
    input  logic             release_pulse,
    output logic             sys_rst,
    output logic             tbc_clr,
    output logic [VEC_W-1:0] rst_vector
);
    localparam int SYNC_BITS = NKEY + 1;

    logic [SYNC_BITS-1:0] raw_in, synced;
    req_t                 req;
    logic                 osc_q;

    assign raw_in = {key_in, ext_rst_pin};

    sysrst_sync #(.W(SYNC_BITS)) u_sync (
        .clk (clk),
        .rst (por),
        .d   (raw_in),
        .q   (synced)
    );

    sysrst_pin_smp u_pin (
        .clk      (clk),
        .rst      (por),
        .stb      (stb_2k),
        .pin_sync (synced[0]),
        .pin_req  (req.pin)
    );

    sysrst_chord #(.N(NKEY)) u_chord (
        .clk       (clk),
        .rst       (por),
        .stb       (stb_1hz),
        .sel       (chord_sel_e'(chord_sel)),
        .keys      (synced[SYNC_BITS-1:1]),
        .chord_req (req.chord)
    );

    always_ff @(posedge clk) begin
        if (por) osc_q <= 1'b0;
        else     osc_q <= osc_stopped & osc_chk_en;
    end
    assign req.osc = osc_q;

    sysrst_latch u_latch (
        .clk           (clk),
        .rst           (por),
        .req           (req),
        .release_pulse (release_pulse),
        .sys_rst       (sys_rst)
    );

    assign tbc_clr    = any_req(req);
    assign rst_vector = '0;

    // R5: oscillator request only follows an enabled option
    p_osc_gated_r5: assert property (@(posedge clk) disable iff (por)
        req.osc |-> $past(osc_chk_en));
    // R8: counter clear implies the latch is or becomes set
    p_tbc_sets_r8: assert property (@(posedge clk) disable iff (por)
        tbc_clr |=> sys_rst);
    // R9: restart address is zero
    always_comb p_vec_zero_r9: assert (rst_vector == '0);
endmodule

// File: tb/sysrst_gen_bench.sv
module sysrst_gen_bench;
    logic        clk = 1'b0;
    logic        por = 1'b1;
    logic        stb_2k = 1'b0, stb_1hz = 1'b0;
    logic        ext_rst_pin = 1'b0;
    logic [3:0]  key_in = 4'b0;
    logic        osc_stopped = 1'b0;
    logic [1:0]  chord_sel = 2'b00;
    logic        osc_chk_en = 1'b0;
    logic        release_pulse = 1'b0;
    logic        sys_rst, tbc_clr;
    logic [15:0] rst_vector;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    sysrst_gen u_sysrst_gen (
        .clk(clk), .por(por), .stb_2k(stb_2k), .stb_1hz(stb_1hz),
        .ext_rst_pin(ext_rst_pin), .key_in(key_in), .osc_stopped(osc_stopped),
        .chord_sel(chord_sel), .osc_chk_en(osc_chk_en),
        .release_pulse(release_pulse), .sys_rst(sys_rst), .tbc_clr(tbc_clr),
        .rst_vector(rst_vector)
    );

    // {chord_sel[1:0], key_in[3:0], expect_accept}
    localparam logic [6:0] VEC [0:9] = '{
        7'b00_0011_1, 7'b00_0001_0, 7'b00_1011_1, 7'b00_1100_0,
        7'b01_0111_1, 7'b01_0011_0, 7'b01_1111_1,
        7'b10_1111_1, 7'b10_0111_0, 7'b11_1111_1
    };

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_1hz();
        stb_1hz = 1'b1; step(); stb_1hz = 1'b0;
    endtask

    task automatic pulse_2k();
        stb_2k = 1'b1; step(); stb_2k = 1'b0;
    endtask

    task automatic pulse_release();
        release_pulse = 1'b1; step(); release_pulse = 1'b0;
    endtask

    task automatic power_on();
        por = 1'b1; step(2); por = 1'b0; step();
        pulse_release();
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        step(2);
        check("R1 sys_rst during por", {15'b0, sys_rst}, 16'h1);
        por = 1'b0; step();
        check("R1 sys_rst after por", {15'b0, sys_rst}, 16'h1);
        check("R1 tbc_clr idle", {15'b0, tbc_clr}, 16'h0);
        check("R9 rst_vector", rst_vector, 16'h0000);
        pulse_release();
        check("R7 release with no source", {15'b0, sys_rst}, 16'h0);

        // R3 table walk: two consecutive samples per vector
        for (int v = 0; v < 10; v++) begin
            power_on();
            chord_sel = VEC[v][6:5];
            key_in    = VEC[v][4:1];
            step(3);
            pulse_1hz();
            pulse_1hz();
            check($sformatf("R3 R8 tbc_clr vec%0d", v), {15'b0, tbc_clr}, {15'b0, VEC[v][0]});
            step();
            check($sformatf("R3 R6 sys_rst vec%0d", v), {15'b0, sys_rst}, {15'b0, VEC[v][0]});
            key_in = 4'b0;
        end

        // R4: a single sample is not enough; a gap restarts
        power_on();
        chord_sel = 2'b10; key_in = 4'b1111; step(3);
        pulse_1hz(); step();
        check("R4 one sample only", {15'b0, sys_rst}, 16'h0);
        key_in = 4'b0; step(3); pulse_1hz();
        key_in = 4'b1111; step(3); pulse_1hz(); step();
        check("R4 gap between samples", {15'b0, sys_rst}, 16'h0);
        pulse_1hz(); step();
        check("R4 second consecutive sample", {15'b0, sys_rst}, 16'h1);
        key_in = 4'b0;

        // R2: pin high without strobe is unseen
        power_on();
        ext_rst_pin = 1'b1; step(10);
        check("R2 pin without strobe", {15'b0, sys_rst}, 16'h0);
        check("R2 R8 tbc_clr without strobe", {15'b0, tbc_clr}, 16'h0);
        ext_rst_pin = 1'b0; step(3); pulse_2k(); step();
        check("R2 short pin missed", {15'b0, sys_rst}, 16'h0);

        // R2 R6 R7 R8: sampled pin sets, release blocked while active
        ext_rst_pin = 1'b1; step(3); pulse_2k();
        check("R8 tbc_clr on pin sample", {15'b0, tbc_clr}, 16'h1);
        step();
        check("R2 pin sampled sets reset", {15'b0, sys_rst}, 16'h1);
        pulse_release(); step();
        check("R7 release blocked by pin", {15'b0, sys_rst}, 16'h1);
        ext_rst_pin = 1'b0; step(3); pulse_2k();
        check("R8 tbc_clr drops", {15'b0, tbc_clr}, 16'h0);
        step(2);
        check("R6 latch holds after source gone", {15'b0, sys_rst}, 16'h1);
        pulse_release();
        check("R7 release after source gone", {15'b0, sys_rst}, 16'h0);

        // R5: oscillator source gated by option
        osc_stopped = 1'b1; osc_chk_en = 1'b0; step(5);
        check("R5 osc disabled", {15'b0, sys_rst}, 16'h0);
        check("R5 osc disabled tbc", {15'b0, tbc_clr}, 16'h0);
        osc_chk_en = 1'b1; step();
        check("R5 R8 osc tbc_clr", {15'b0, tbc_clr}, 16'h1);
        step();
        check("R5 osc enabled reset", {15'b0, sys_rst}, 16'h1);
        osc_stopped = 1'b0; osc_chk_en = 1'b0;
        check("R9 rst_vector later", rst_vector, 16'h0000);

        done = 1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            finish_run();
        end
    end
endmodule